// File: doc/BRIEF.md
# Staggered Reset Sequencer

This block turns one asynchronous power-on reset into a set of per-module active-low reset outputs. They are released in a fixed order once the clocks are stable. While the power-on input is low, every output is forced low at once, without waiting for a clock. When the power-on input goes high, its release is first passed through a synchroniser. The block then waits until the clock divider reports that it has reloaded its configuration. After that it keeps every module in reset together for a programmable number of common cycles.

After that window, a shift chain releases the module resets one per clock. Module 0 comes out first and the highest-numbered module comes out last. The chain is built this way so that the whole load never comes out of reset in the same cycle. The CPU subsystem reset is the final stage of the chain, so the processor only starts once every memory and peripheral it might touch is running. A done flag then reports that the sequence is complete.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_n` is low, every bit of `mod_rst_n`, `cpu_rst_n` and `sequence_done` is 0. A falling edge of `por_n` forces them to 0 with no clock edge needed, even in the middle of a sequence.
- R2: The rising edge of `por_n` passes through a two-flop synchroniser. A `div_reload` sampled on the first or second rising clock edge after `por_n` rises is ignored.
- R3: No output leaves reset until `div_reload` is sampled high on the third or a later rising edge after `por_n` rises. Call that edge R.
- R4: All outputs stay low together through edge R+HOLD_CYCLES, where HOLD_CYCLES defaults to 8. Module 0 (bit 0 of `mod_rst_n`) goes high at edge R+HOLD_CYCLES+1.
- R5: Module k goes high at edge R+HOLD_CYCLES+1+k. Exactly one reset output changes per clock edge during the release.
- R6: `cpu_rst_n` goes high at edge R+HOLD_CYCLES+1+NUM_MODULES, after every bit of `mod_rst_n` is already high.
- R7: `sequence_done` goes high one edge after `cpu_rst_n` and stays high until the next power-on reset.
- R8: Once the hold window has started, further `div_reload` pulses have no effect on the release timing.
- R9: When `por_n` is reasserted and then released, a full new sequence runs. That sequence again waits for a fresh `div_reload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| div_reload | input | 1 | Pulse from the clock divider when it loads its configuration |
| mod_rst_n | output | NUM_MODULES | Per-module resets, active low; bit 0 is released first |
| cpu_rst_n | output | 1 | CPU subsystem reset, active low, released last |
| sequence_done | output | 1 | High once the CPU reset has been released |

## Verification
Two situations are hard to reach from the ports: a reload that arrives while the synchroniser is still filling, and a power-on reset that returns after part of the chain has been released. The bench sweeps the delay between synchroniser release and the reload pulse. Some runs also inject a reload on the first two edges, and others inject extra reload pulses during the hold and shift phases. The release of `por_n` is timed to an exact clock edge, so the expected value of every output can be computed arithmetically for every cycle. One run pulls `por_n` low in the middle of the shift phase and checks the outputs before the next clock edge. It then repeats a full sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_SHIFT = 2'd2,
        PH_DONE  = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_sync_n
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[SYNC_STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rst_sync_n = sync_q.pipe[SYNC_STAGES-1];

    // R2: the synchronised release never rises in the cycle that follows the power-on edge
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_sync_n) |-> $past(arst_n));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_reload,
    input  logic chain_full,
    output logic shift_en,
    output logic done
);

    localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        seq_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.phase)
            PH_WAIT: begin
                if (div_reload) begin
                    ctrl_d.phase = PH_HOLD;
                    ctrl_d.cnt   = '0;
                end
            end
            PH_HOLD: begin
                if (ctrl_q.cnt == CNT_LAST) begin
                    ctrl_d.phase = PH_SHIFT;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            PH_SHIFT: begin
                if (chain_full) begin
                    ctrl_d.phase = PH_DONE;
                end
            end
            default: begin
                ctrl_d.phase = PH_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_WAIT, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign shift_en = (ctrl_q.phase == PH_SHIFT);
    assign done     = (ctrl_q.phase == PH_DONE);

    // R3: without a reload the sequencer stays in its waiting phase
    assert_wait_for_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_WAIT && !div_reload) |=> (ctrl_q.phase == PH_WAIT));

    // R4: the shift phase is entered only after the full common hold window
    assert_hold_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_SHIFT && $past(ctrl_q.phase) != PH_SHIFT)
            |-> ($past(ctrl_q.phase) == PH_HOLD && $past(ctrl_q.cnt) == CNT_LAST));

    // R8: once past the waiting phase the sequencer never goes back to it
    assert_no_rewait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase != PH_WAIT) |=> (ctrl_q.phase != PH_WAIT));

endmodule

// File: rtl/rst_seq_chain.sv
module rst_seq_chain #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    output logic [STAGES-1:0] rel,
    output logic              chain_full
);

    typedef struct packed {
        logic [STAGES-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.bits[0] = 1'b1;
            for (int i = 1; i < STAGES; i++) begin
                chain_d.bits[i] = chain_q.bits[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign rel        = chain_q.bits;
    assign chain_full = chain_q.bits[STAGES-1];

    // R5: at most one stage changes on any clock edge
    assert_one_per_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chain_q.bits ^ $past(chain_q.bits)) <= 1);

    // R5: a released stage is never taken back into reset without a power-on reset
    assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_q.bits) & ~chain_q.bits) == '0);

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int NUM_MODULES = 4,
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   div_reload,
    output logic [NUM_MODULES-1:0] mod_rst_n,
    output logic                   cpu_rst_n,
    output logic                   sequence_done
);

    localparam int STAGES = NUM_MODULES + 1;

    logic              rst_sync_n;
    logic              shift_en;
    logic              chain_full;
    logic [STAGES-1:0] rel;

    rst_seq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .arst_n     (por_n),
        .rst_sync_n (rst_sync_n)
    );

    rst_seq_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .div_reload (div_reload),
        .chain_full (chain_full),
        .shift_en   (shift_en),
        .done       (sequence_done)
    );

    rst_seq_chain #(.STAGES(STAGES)) u_chain (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .shift_en   (shift_en),
        .rel        (rel),
        .chain_full (chain_full)
    );

    assign mod_rst_n = rel[NUM_MODULES-1:0];
    assign cpu_rst_n = rel[NUM_MODULES];

    // R1: power-on reset holds every output low
    assert_por_forces_reset_R1: assert property (@(posedge clk)
        !por_n |-> (mod_rst_n == '0 && !cpu_rst_n && !sequence_done));

    // R6: the CPU leaves reset only after all modules
    assert_cpu_last_R6: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst_n |-> (&mod_rst_n));

    // R7: done is reported only with the CPU out of reset, and it stays up
    assert_done_after_cpu_R7: assert property (@(posedge clk) disable iff (!por_n)
        sequence_done |-> cpu_rst_n);
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        sequence_done |=> sequence_done);

endmodule

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;

    localparam int N = 4;
    localparam int H = 8;
    localparam int W = N + 2;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         div_reload = 1'b0;
    logic [N-1:0] mod_rst_n;
    logic         cpu_rst_n;
    logic         sequence_done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rst_seq_top #(.NUM_MODULES(N), .HOLD_CYCLES(H), .SYNC_STAGES(2)) u_rst_seq_top (
        .clk           (clk),
        .por_n         (por_n),
        .div_reload    (div_reload),
        .mod_rst_n     (mod_rst_n),
        .cpu_rst_n     (cpu_rst_n),
        .sequence_done (sequence_done)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        logic [W-1:0] act;
        act = {sequence_done, cpu_rst_n, mod_rst_n};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Expected {done, cpu, modules} after edge e, when the reload was sampled at edge r
    function automatic logic [W-1:0] expect_at(input int e, input int r);
        logic [W-1:0] v;
        v = '0;
        for (int k = 0; k < N; k++) v[k] = (e >= r + H + 1 + k);
        v[N]   = (e >= r + H + 1 + N);
        v[N+1] = (e >= r + H + 2 + N);
        return v;
    endfunction

    // delay: edges between the synchroniser release and the reload edge
    // early: reload also on edges 1 and 2 (R2); extra: pulses during hold and shift (R8)
    // abort_at: pull por_n low after this edge (0 = never)
    task automatic run_seq(input int delay, input bit early, input bit extra, input int abort_at);
        int r;
        int last;
        r    = 3 + delay;
        last = r + H + N + 5;
        @(negedge clk);
        por_n      = 1'b0;
        div_reload = 1'b0;
        #1 check("R1 async assert", '0);
        repeat (3) @(negedge clk);
        check("R1 held in reset", '0);
        por_n      = 1'b1;
        div_reload = early;
        for (int e = 1; e <= last; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e < r)
                check("R3 wait for reload", expect_at(e, r));
            else if (e <= r + H)
                check("R4 common hold", expect_at(e, r));
            else if (e < r + H + 1 + N)
                check("R5 staggered release", expect_at(e, r));
            else if (e == r + H + 1 + N)
                check("R6 cpu last", expect_at(e, r));
            else
                check(extra ? "R8 late reload ignored" :
                      (early ? "R2 early reload ignored" : "R7 done flag"), expect_at(e, r));
            div_reload = ((e + 1) == r) || (early && e < 2) ||
                         (extra && ((e + 1) == r + 2 || (e + 1) == r + H + 2));
            if (abort_at != 0 && e == abort_at) begin
                #2 por_n = 1'b0;
                div_reload = 1'b0;
                #1 check("R9 mid-sequence reset", '0);
                return;
            end
        end
        div_reload = 1'b0;
    endtask

    initial begin
        #1 check("R1 reset state", '0);
        for (int d = 0; d <= 5; d++) begin
            run_seq(d, 1'b0, 1'b0, 0);
        end
        run_seq(0, 1'b1, 1'b0, 0);
        run_seq(2, 1'b1, 1'b0, 0);
        run_seq(1, 1'b0, 1'b1, 0);
        run_seq(3, 1'b0, 1'b1, 0);
        run_seq(1, 1'b0, 1'b0, 4 + H + 2);
        // R9: full fresh sequence after the abort, with a new reload required
        run_seq(4, 1'b0, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule